// File: doc/BRIEF.md
# Speculative Store Queue

This block keeps store operations in program order from the moment they are allocated until their data reaches the L1 data cache. Each held store carries an address, a data word and a byte-enable mask. A held store is at first speculative. The retire input then turns the oldest speculative stores into retired stores. A retired store can no longer be undone, and the reorder buffer may free its slot at once. The cache-write port then sends retired stores to the cache, oldest first, one for each accepted handshake.

A flush discards every store that is still speculative and frees their slots in the same cycle. Stores that have already retired stay in the queue and keep draining. Retirement never waits on the cache port, so a slow or missing cache write cannot hold back retirement. A drained flag tells fences and interrupt logic when no retired store is left to write.

Top module: `spec_store_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_full` is 0, `drained` is 1 and `wr_valid` is 0.
- R2: The cache-write port presents stores in exactly the order they were allocated. Address, data and mask are passed through unchanged.
- R3: A speculative store is never presented on the cache-write port. `wr_valid` is 1 only while at least one retired store is held.
- R4: `retire_cnt` retires that many of the oldest speculative stores. A count larger than the number of speculative stores retires only the stores that exist.
- R5: On a cycle with `flush` high, every store still speculative after that cycle's retirement is discarded. Retired stores are kept and are written later, in order.
- R6: `alloc_full` is 1 when all DEPTH slots (16 by default) are occupied. An allocation attempted while it is 1 is refused and leaves no trace.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, the presented store holds steady. A store leaves the queue only in the cycle its write is accepted.
- R8: `drained` is 1 exactly when no retired store remains unwritten.
- R9: Retirement goes ahead while the cache port is stalled (`wr_ready` low).
- R10: Slots freed by a flush can be allocated again from the next cycle; `alloc_full` falls right after the flush.
- R11: An allocation presented in the same cycle as `flush` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a new store this cycle |
| alloc_addr | input | AW (32) | Store address |
| alloc_data | input | DW (32) | Store data |
| alloc_mask | input | DW/8 (4) | Byte enables |
| alloc_full | output | 1 | No free slot; allocation refused |
| retire_cnt | input | $clog2(DEPTH)+1 (5) | Number of oldest speculative stores to retire |
| flush | input | 1 | Discard all speculative stores |
| wr_valid | output | 1 | A retired store is offered to the cache |
| wr_ready | input | 1 | Cache accepts the offered store |
| wr_addr | output | AW (32) | Address of the offered store |
| wr_data | output | DW (32) | Data of the offered store |
| wr_mask | output | DW/8 (4) | Byte enables of the offered store |
| drained | output | 1 | No retired store remains |

## Verification
A table of six stores, each with its own address, data and mask, is allocated and then drained. This shows whether the ordering and the field routing on the cache port are correct. The stores are first retired in a partial batch while the port is stalled, which separates retirement from draining, and then in an oversized batch, which shows whether the count is clamped. A mixed retired/speculative flush, with an allocation in the same cycle, shows whether the flush stops at the retire boundary. A fill to capacity, with a refused extra store followed by a flush and a re-allocation, shows whether full-refusal works and whether freed slots are reused.

// File: rtl/spec_store_queue.sv
module spec_store_queue #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  input  logic [AW-1:0]              alloc_addr,
  input  logic [DW-1:0]              alloc_data,
  input  logic [DW/8-1:0]            alloc_mask,
  output logic                       alloc_full,
  input  logic [$clog2(DEPTH):0]     retire_cnt,
  input  logic                       flush,
  output logic                       wr_valid,
  input  logic                       wr_ready,
  output logic [AW-1:0]              wr_addr,
  output logic [DW-1:0]              wr_data,
  output logic [DW/8-1:0]            wr_mask,
  output logic                       drained
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int MW = DW / 8;

  logic [AW-1:0] mem_addr [DEPTH];
  logic [DW-1:0] mem_data [DEPTH];
  logic [MW-1:0] mem_mask [DEPTH];

  logic [PW-1:0] head;
  logic [CW-1:0] n_all, n_ret;

  logic [CW-1:0] n_spec, take;
  logic [PW-1:0] tail;
  logic          push, pop;

  assign n_spec     = n_all - n_ret;
  assign take       = (retire_cnt > n_spec) ? n_spec : retire_cnt;
  assign tail       = head + n_all[PW-1:0];
  assign alloc_full = (n_all == CW'(DEPTH));
  assign push       = alloc_valid && !alloc_full && !flush;
  assign wr_valid   = (n_ret != '0);
  assign pop        = wr_valid && wr_ready;
  assign drained    = (n_ret == '0);
  assign wr_addr    = mem_addr[head];
  assign wr_data    = mem_data[head];
  assign wr_mask    = mem_mask[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      n_all <= '0;
      n_ret <= '0;
    end else begin
      head  <= head + PW'(pop);
      n_ret <= n_ret + take - CW'(pop);
      if (flush) n_all <= n_ret + take - CW'(pop);
      else       n_all <= n_all + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_addr[tail] <= alloc_addr;
      mem_data[tail] <= alloc_data;
      mem_mask[tail] <= alloc_mask;
    end
  end

  // R6: occupancy never exceeds capacity
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    n_all <= CW'(DEPTH));

  // R4: retired count never passes the allocated count
  a_r4_ret_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    n_ret <= n_all);

  // R7: a stalled write holds its store
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_mask));

  // R7: the oldest store moves only on an accepted write
  a_r7_head_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(head));

  // R5: after a flush only retired stores remain
  a_r5_flush_keeps_retired: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> n_all == n_ret);

  // R10: a flush leaves room
  a_r10_flush_frees: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !(retire_cnt >= n_spec && n_all == CW'(DEPTH) && !pop) |=> !alloc_full);
endmodule

// File: tb/test_spec_store_queue.sv
module test_spec_store_queue;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0;
  logic [31:0] alloc_addr = '0, alloc_data = '0;
  logic [3:0]  alloc_mask = '0;
  logic alloc_full;
  logic [CW-1:0] retire_cnt = '0;
  logic flush = 0;
  logic wr_valid, wr_ready = 0;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_mask;
  logic drained;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  spec_store_queue i_spec_store_queue (
    .clk, .rst_n, .alloc_valid, .alloc_addr, .alloc_data, .alloc_mask, .alloc_full,
    .retire_cnt, .flush, .wr_valid, .wr_ready, .wr_addr, .wr_data, .wr_mask, .drained);

  localparam logic [67:0] VEC [6] = '{
    {32'h0000_1000, 32'hDEAD_BEEF, 4'hF},
    {32'h0000_2004, 32'h1234_5678, 4'h3},
    {32'h8000_0010, 32'hA5A5_5A5A, 4'hC},
    {32'h0000_1000, 32'h0000_0001, 4'h1},
    {32'hFFFF_FFFC, 32'hCAFE_F00D, 4'h8},
    {32'h0040_0020, 32'h7777_0000, 4'h6}
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(string req, logic [67:0] act, logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic alloc(logic [67:0] v);
    alloc_valid = 1; {alloc_addr, alloc_data, alloc_mask} = v;
    tick();
    alloc_valid = 0;
  endtask

  task automatic expect_head(string req, logic [67:0] v);
    check(req, {67'b0, wr_valid}, 68'd1);
    check(req, {wr_addr, wr_data, wr_mask}, v);
  endtask

  task automatic drain_one(string req, logic [67:0] v);
    wr_ready = 1;
    expect_head(req, v);
    tick();
    wr_ready = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    // R1 reset state
    check("R1", {65'b0, alloc_full, drained, wr_valid}, {65'b0, 3'b010});

    for (int i = 0; i < 6; i++) alloc(VEC[i]);
    // R3 speculative stores are not offered
    check("R3", {66'b0, wr_valid, drained}, {66'b0, 2'b01});

    // R9 retire while port stalled
    retire_cnt = 2; tick(); retire_cnt = 0;
    check("R9", {67'b0, drained}, 68'd0);
    expect_head("R9", VEC[0]);
    tick(); tick();
    // R7 holds under stall
    expect_head("R7", VEC[0]);

    // R4 oversized retire clamps to the four remaining
    retire_cnt = 10; tick(); retire_cnt = 0;
    flush = 1; tick(); flush = 0;
    for (int i = 0; i < 6; i++) drain_one("R2", VEC[i]);
    // R8 drained once nothing retired remains
    check("R8", {66'b0, drained, wr_valid}, {66'b0, 2'b10});

    // R5 / R11 flush at retire boundary
    alloc({32'hA0, 32'h1, 4'h1});
    alloc({32'hB0, 32'h2, 4'h2});
    alloc({32'hC0, 32'h3, 4'h4});
    retire_cnt = 1; tick(); retire_cnt = 0;
    flush = 1; alloc_valid = 1; {alloc_addr, alloc_data, alloc_mask} = {32'hD0, 32'h4, 4'h8};
    tick(); flush = 0; alloc_valid = 0;
    retire_cnt = 3; tick(); retire_cnt = 0;
    drain_one("R5", {32'hA0, 32'h1, 4'h1});
    check("R11", {66'b0, wr_valid, drained}, {66'b0, 2'b01});

    // R6 fill to capacity, refuse extra
    for (int i = 0; i < DEPTH; i++) begin
      check("R6", {67'b0, alloc_full}, 68'd0);
      alloc({32'h1000 + 32'(i * 4), 32'(i), 4'hF});
    end
    check("R6", {67'b0, alloc_full}, 68'd1);
    alloc({32'hBAD0, 32'hBAD, 4'hF});
    check("R6", {67'b0, alloc_full}, 68'd1);
    // R10 flush frees space immediately
    retire_cnt = 2; tick(); retire_cnt = 0;
    flush = 1; tick(); flush = 0;
    check("R10", {67'b0, alloc_full}, 68'd0);
    alloc({32'h5550, 32'h55, 4'h5});
    retire_cnt = 16; tick(); retire_cnt = 0;
    drain_one("R6", {32'h1000, 32'd0, 4'hF});
    drain_one("R6", {32'h1004, 32'd1, 4'hF});
    drain_one("R10", {32'h5550, 32'h55, 4'h5});
    check("R8", {66'b0, drained, wr_valid}, {66'b0, 2'b10});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule